// File: doc/BRIEF.md
# Sleep Entry and Wakeup Controller

This block runs in the always-on slow-clock domain and sequences the chip into and out of a low-power state. Before issuing a start strobe, software sets up the following:

- a depth selection, light or deep;
- a power-down flag word covering the digital domain, the RTC peripherals, the two RTC memories, a memory-follows-CPU option, the I/O regulator and the main crystal;
- active and sleep bias codes for the digital and RTC domains;
- a wakeup-enable mask;
- a reject mask.

The block latches the configuration on the start strobe. It first tests whether an enabled reject condition was active at that moment. If none was, it drives the power-down controls and lowers the bias codes. It then waits for an enabled wakeup event, which can be a raw event line or a match between the 48-bit RTC counter and a programmed target.

When sleep ends, the outcome depends on the depth. A light-sleep wake or any rejection returns a one-cycle done pulse together with a one-hot cause or a rejection flag. A deep-sleep wake raises a one-cycle CPU reset request instead. Some wake sources only operate in light sleep, and in deep sleep they are masked out.

Top module: `slp_ctrl`

## Requirements
- R1: After reset, `pd_out`, `done`, `rejected`, `cpu_reset_req` and `wake_cause` are all zero. `dig_bias` and `rtc_bias` equal the active (wake) bias inputs.
- R2: `reject_en`/`reject_lines` bit 0 is GPIO activity and bit 1 is SDIO activity. If any bit is set in both at the start strobe, the block never asserts `pd_out`. In the second cycle after the strobe it pulses `done` with `rejected`=1, `wake_cause`=0 and no `cpu_reset_req`. A reject line without its enable bit set does not stop entry.
- R3: `pd_out` is zero in the first cycle after the start strobe. From the second cycle it equals the flag word latched at the strobe, and it stays there until the wake. Bit order: 0 digital domain, 1 RTC peripherals, 2 RTC slow memory, 3 RTC fast memory, 4 memories follow CPU, 5 I/O regulator, 6 main crystal. The crystal is powered down (`pd_out[6]`=1) only if its flag is set.
- R4: While `pd_out` is applied, `dig_bias`/`rtc_bias` carry the sleep bias inputs. At all other times they carry the active bias inputs.
- R5: Wake mask bit order: 0 EXT0, 1 EXT1, 2 GPIO, 3 timer, 4 SDIO, 5 MAC, 6 UART0, 7 UART1, 8 touch, 9 coprocessor, 10 BT. Only an event whose enable bit is set, seen while asleep, ends sleep. Events on disabled lines leave `pd_out` applied.
- R6: In deep sleep, enable bits 2, 4, 5, 6, 7 and 10 are ignored. An event on such a line does not wake the block.
- R7: The timer source (bit 3) fires when `rtc_count` equals `wake_target`. The raw `wake_lines[3]` input is ignored.
- R8: `wake_cause` holds, one-hot, the first enabled event seen. Simultaneous events resolve to the lowest bit index. The value is held until the next start strobe, which clears it.
- R9: A light-sleep wake pulses `done` (with `rejected`=0) for one cycle and never asserts `cpu_reset_req`. A deep-sleep wake pulses `cpu_reset_req` for one cycle and never asserts `done`.
- R10: `pd_out` is released in the cycle after the wake event is sampled. The done or reset pulse follows one cycle later, and the block then returns to idle and accepts a new strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Slow always-on clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Sleep start strobe, sampled while idle |
| cfg_deep | input | 1 | 1 selects deep sleep, 0 selects light sleep |
| cfg_pd_flags | input | 7 | Power-down flag word |
| cfg_dig_bias_wake | input | 3 | Digital-domain bias code while awake |
| cfg_dig_bias_sleep | input | 3 | Digital-domain bias code while asleep |
| cfg_rtc_bias_wake | input | 3 | RTC-domain bias code while awake |
| cfg_rtc_bias_sleep | input | 3 | RTC-domain bias code while asleep |
| wake_en | input | 11 | Wakeup-enable mask |
| reject_en | input | 2 | Reject enable mask |
| reject_lines | input | 2 | Reject activity inputs (GPIO, SDIO) |
| wake_lines | input | 11 | Raw wakeup event lines (bit 3 unused) |
| rtc_count | input | 48 | Free-running RTC counter |
| wake_target | input | 48 | Timer wakeup target |
| pd_out | output | 7 | Power-down controls |
| dig_bias | output | 3 | Applied digital-domain bias code |
| rtc_bias | output | 3 | Applied RTC-domain bias code |
| wake_cause | output | 11 | One-hot latched wakeup cause |
| rejected | output | 1 | Last attempt was rejected |
| done | output | 1 | One-cycle completion pulse (light wake or reject) |
| cpu_reset_req | output | 1 | One-cycle CPU reset request after a deep wake |

## Verification
The main sequence is exercised with several sleep attempts:

- A light-sleep UART wake. This separates light-only handling from deep handling and shows the done path.
- A deep-sleep attempt in which an enabled light-only event arrives first and an enabled touch event follows. This shows that depth masking works and that only the second event wakes the block.
- A two-event tie, which exposes the priority direction.
- A timer attempt in which the raw bit-3 line pulses while the counter does not match, and the counter is then brought to the target. This tells the comparator apart from the raw line.

Two reject attempts cover the enabled and the unmasked cases. Separate flag words with the crystal bit clear and set show that the power-down bits keep their positions.

// File: rtl/slp_pkg.sv
package slp_pkg;
  localparam int WAKE_N  = 11;
  localparam int PD_N    = 7;
  localparam int REJ_N   = 2;
  localparam int BIAS_W  = 3;
  localparam int CNT_W   = 48;
  localparam int TMR_BIT = 3;

  // Wake sources that only operate in light sleep: GPIO, SDIO, MAC, UART0, UART1, BT
  localparam logic [WAKE_N-1:0] LIGHT_ONLY = 11'b100_1111_0100;

  typedef enum logic [2:0] {
    ST_IDLE, ST_CHECK, ST_PWRDN, ST_SLEEP, ST_WAKE, ST_DONE
  } slp_state_e;

  // isolate the lowest set bit
  function automatic logic [WAKE_N-1:0] lowest_set(input logic [WAKE_N-1:0] v);
    return v & (~v + 1'b1);
  endfunction

  // sources usable at the selected depth
  function automatic logic [WAKE_N-1:0] depth_mask(input logic deep);
    return deep ? ~LIGHT_ONLY : '1;
  endfunction
endpackage

// File: rtl/slp_timer_match.sv
module slp_timer_match #(
  parameter int CW = 48
) (
  input  logic [CW-1:0] count,
  input  logic [CW-1:0] target,
  output logic          hit
);
  assign hit = (count == target);
endmodule

// File: rtl/slp_wake_filter.sv
module slp_wake_filter
  import slp_pkg::*;
#(
  parameter int N = WAKE_N
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         deep,
  input  logic [N-1:0] enable,
  input  logic [N-1:0] events,
  output logic [N-1:0] first
);
  logic [N-1:0] gated;

  assign gated = events & enable & depth_mask(deep);
  assign first = lowest_set(gated);

  assert_deep_mask_R6: assert property (@(posedge clk) disable iff (!rst_n)
    deep |-> ((first & LIGHT_ONLY) == '0));
  assert_first_onehot_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(first) && ((first & ~events) == '0));
endmodule

// File: rtl/slp_seq_fsm.sv
module slp_seq_fsm
  import slp_pkg::*;
#(
  parameter int NW = WAKE_N,
  parameter int NP = PD_N,
  parameter int NR = REJ_N
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic          deep_in,
  input  logic [NP-1:0] pd_flags_in,
  input  logic [NW-1:0] wake_en_in,
  input  logic [NR-1:0] rej_en_in,
  input  logic [NR-1:0] rej_lines_in,
  input  logic [NW-1:0] first_evt,
  output logic          deep_q,
  output logic [NW-1:0] en_q,
  output logic [NP-1:0] pd_q,
  output logic          asleep,
  output logic [NW-1:0] cause_q,
  output logic          rejd_q,
  output logic          done,
  output logic          reset_req
);
  slp_state_e    state;
  logic [NP-1:0] flags_q;
  logic          rej_hit_q;
  logic          wake_seen;

  assign wake_seen = (state == ST_SLEEP) && (first_evt != '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state     <= ST_IDLE;
      deep_q    <= 1'b0;
      en_q      <= '0;
      flags_q   <= '0;
      rej_hit_q <= 1'b0;
      rejd_q    <= 1'b0;
      cause_q   <= '0;
      pd_q      <= '0;
    end else begin
      case (state)
        ST_IDLE: if (start) begin
          deep_q    <= deep_in;
          en_q      <= wake_en_in;
          flags_q   <= pd_flags_in;
          rej_hit_q <= |(rej_en_in & rej_lines_in);
          rejd_q    <= 1'b0;
          cause_q   <= '0;
          state     <= ST_CHECK;
        end
        ST_CHECK: begin
          if (rej_hit_q) begin
            rejd_q <= 1'b1;
            state  <= ST_DONE;
          end else begin
            pd_q  <= flags_q;
            state <= ST_PWRDN;
          end
        end
        ST_PWRDN: state <= ST_SLEEP;
        ST_SLEEP: if (wake_seen) begin
          cause_q <= first_evt;
          pd_q    <= '0;
          state   <= ST_WAKE;
        end
        ST_WAKE: state <= ST_DONE;
        default: state <= ST_IDLE;
      endcase
    end
  end

  assign asleep    = (state == ST_PWRDN) || (state == ST_SLEEP);
  assign done      = (state == ST_DONE) && (!deep_q || rejd_q);
  assign reset_req = (state == ST_DONE) && deep_q && !rejd_q;

  assert_pd_only_asleep_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (pd_q != '0) |-> asleep);
  assert_reject_no_pd_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_CHECK && rej_hit_q) |=> (pd_q == '0) && done);
  assert_cause_onehot_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(cause_q));
  assert_exit_exclusive_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !(done && reset_req));
  assert_release_on_wake_R10: assert property (@(posedge clk) disable iff (!rst_n)
    wake_seen |=> (pd_q == '0) && (cause_q != '0));
endmodule

// File: rtl/slp_ctrl.sv
module slp_ctrl
  import slp_pkg::*;
#(
  parameter int NW = WAKE_N,
  parameter int NP = PD_N,
  parameter int NR = REJ_N,
  parameter int BW = BIAS_W,
  parameter int CW = CNT_W,
  parameter int TB = TMR_BIT
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic          cfg_deep,
  input  logic [NP-1:0] cfg_pd_flags,
  input  logic [BW-1:0] cfg_dig_bias_wake,
  input  logic [BW-1:0] cfg_dig_bias_sleep,
  input  logic [BW-1:0] cfg_rtc_bias_wake,
  input  logic [BW-1:0] cfg_rtc_bias_sleep,
  input  logic [NW-1:0] wake_en,
  input  logic [NR-1:0] reject_en,
  input  logic [NR-1:0] reject_lines,
  input  logic [NW-1:0] wake_lines,
  input  logic [CW-1:0] rtc_count,
  input  logic [CW-1:0] wake_target,
  output logic [NP-1:0] pd_out,
  output logic [BW-1:0] dig_bias,
  output logic [BW-1:0] rtc_bias,
  output logic [NW-1:0] wake_cause,
  output logic          rejected,
  output logic          done,
  output logic          cpu_reset_req
);
  localparam logic [NW-1:0] TMR_MASK = NW'(1) << TB;

  logic          tmr_hit;
  logic [NW-1:0] evt_eff;
  logic [NW-1:0] first_evt;
  logic [NW-1:0] en_q;
  logic          deep_q;
  logic          asleep;

  slp_timer_match #(.CW(CW)) u_tmr (
    .count(rtc_count), .target(wake_target), .hit(tmr_hit)
  );

  // raw line at the timer position is replaced by the comparator result
  assign evt_eff = (wake_lines & ~TMR_MASK) | (tmr_hit ? TMR_MASK : '0);

  slp_wake_filter #(.N(NW)) u_filt (
    .clk(clk), .rst_n(rst_n), .deep(deep_q), .enable(en_q),
    .events(evt_eff), .first(first_evt)
  );

  slp_seq_fsm #(.NW(NW), .NP(NP), .NR(NR)) u_fsm (
    .clk(clk), .rst_n(rst_n), .start(start), .deep_in(cfg_deep),
    .pd_flags_in(cfg_pd_flags), .wake_en_in(wake_en),
    .rej_en_in(reject_en), .rej_lines_in(reject_lines),
    .first_evt(first_evt), .deep_q(deep_q), .en_q(en_q),
    .pd_q(pd_out), .asleep(asleep), .cause_q(wake_cause),
    .rejd_q(rejected), .done(done), .reset_req(cpu_reset_req)
  );

  assign dig_bias = asleep ? cfg_dig_bias_sleep : cfg_dig_bias_wake;
  assign rtc_bias = asleep ? cfg_rtc_bias_sleep : cfg_rtc_bias_wake;

  assert_bias_low_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (pd_out != '0) |-> (dig_bias == cfg_dig_bias_sleep) && (rtc_bias == cfg_rtc_bias_sleep));
endmodule

// File: tb/slp_ctrl_bench.sv
module slp_ctrl_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic        cfg_deep = 1'b0;
  logic [6:0]  cfg_pd_flags = '0;
  logic [2:0]  dbw = 3'd5, dbs = 3'd2, rbw = 3'd6, rbs = 3'd1;
  logic [10:0] wake_en = '0;
  logic [1:0]  reject_en = '0, reject_lines = '0;
  logic [10:0] wake_lines = '0;
  logic [47:0] rtc_count = 48'd0, wake_target = 48'hFFFF_FFFF_FFFF;
  logic [6:0]  pd_out;
  logic [2:0]  dig_bias, rtc_bias;
  logic [10:0] wake_cause;
  logic        rejected, done, cpu_reset_req;

  int checks = 0, fails = 0;

  always #2.5 clk = ~clk;

  slp_ctrl u_slp_ctrl (
    .clk(clk), .rst_n(rst_n), .start(start), .cfg_deep(cfg_deep),
    .cfg_pd_flags(cfg_pd_flags), .cfg_dig_bias_wake(dbw), .cfg_dig_bias_sleep(dbs),
    .cfg_rtc_bias_wake(rbw), .cfg_rtc_bias_sleep(rbs), .wake_en(wake_en),
    .reject_en(reject_en), .reject_lines(reject_lines), .wake_lines(wake_lines),
    .rtc_count(rtc_count), .wake_target(wake_target), .pd_out(pd_out),
    .dig_bias(dig_bias), .rtc_bias(rtc_bias), .wake_cause(wake_cause),
    .rejected(rejected), .done(done), .cpu_reset_req(cpu_reset_req)
  );

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // strobe start; returns half a cycle after the capturing edge (first cycle after start)
  task automatic pulse_start();
    @(negedge clk) start = 1'b1;
    @(negedge clk) start = 1'b0;
  endtask

  task automatic t_reset();
    chk("R1 pd_out", pd_out, 0);
    chk("R1 done/rej/rst", {done, rejected, cpu_reset_req}, 0);
    chk("R1 cause", wake_cause, 0);
    chk("R1 bias", {dig_bias, rtc_bias}, {dbw, rbw});
  endtask

  task automatic t_light_uart();
    cfg_deep = 0; cfg_pd_flags = 7'b0111110; wake_en = 11'b000_0100_0000;
    pulse_start();
    chk("R3 pd low first cycle", pd_out, 0);
    @(negedge clk);
    chk("R3 pd applied", pd_out, 7'b0111110);
    chk("R3 crystal kept", pd_out[6], 0);
    chk("R4 sleep bias", {dig_bias, rtc_bias}, {dbs, rbs});
    @(negedge clk) wake_lines = 11'b000_0100_0000;
    @(negedge clk) wake_lines = '0;
    chk("R10 pd released", pd_out, 0);
    chk("R8 cause uart0", wake_cause, 11'b000_0100_0000);
    chk("R4 wake bias", {dig_bias, rtc_bias}, {dbw, rbw});
    chk("R10 no pulse yet", {done, cpu_reset_req}, 0);
    @(negedge clk);
    chk("R9 light done", {done, rejected, cpu_reset_req}, 3'b100);
    @(negedge clk);
    chk("R10 back idle", done, 0);
    chk("R8 cause held", wake_cause, 11'b000_0100_0000);
  endtask

  task automatic t_deep_masking();
    cfg_deep = 1; cfg_pd_flags = 7'b1000001; wake_en = 11'b001_0100_0000;
    pulse_start();
    chk("R8 cause cleared on start", wake_cause, 0);
    @(negedge clk);
    chk("R3 crystal down", pd_out, 7'b1000001);
    @(negedge clk) wake_lines = 11'b000_0100_0000;
    repeat (3) @(negedge clk);
    chk("R6 light-only ignored pd", pd_out, 7'b1000001);
    chk("R6 light-only ignored cause", wake_cause, 0);
    wake_lines = 11'b001_0100_0000;
    @(negedge clk) wake_lines = '0;
    chk("R6 touch cause", wake_cause, 11'b001_0000_0000);
    @(negedge clk);
    chk("R9 deep reset", {done, cpu_reset_req}, 2'b01);
    @(negedge clk);
    chk("R9 reset one cycle", cpu_reset_req, 0);
  endtask

  task automatic t_priority();
    cfg_deep = 0; cfg_pd_flags = 7'b0000110; wake_en = '1;
    pulse_start();
    @(negedge clk);
    @(negedge clk) wake_lines = 11'b010_0000_0100;
    @(negedge clk) wake_lines = '0;
    chk("R8 lowest wins", wake_cause, 11'b000_0000_0100);
    repeat (2) @(negedge clk);
  endtask

  task automatic t_disabled_line();
    cfg_deep = 0; cfg_pd_flags = 7'b0000010; wake_en = 11'b000_0000_0001;
    pulse_start();
    @(negedge clk);
    @(negedge clk) wake_lines = 11'b000_0000_0010;
    repeat (2) @(negedge clk);
    chk("R5 disabled ignored", pd_out, 7'b0000010);
    wake_lines = 11'b000_0000_0001;
    @(negedge clk) wake_lines = '0;
    chk("R5 ext0 wake", wake_cause, 11'b000_0000_0001);
    repeat (2) @(negedge clk);
  endtask

  task automatic t_timer();
    cfg_deep = 1; cfg_pd_flags = 7'b0000001; wake_en = 11'b000_0000_1000;
    rtc_count = 48'h1234_5678_9AB0; wake_target = 48'h1234_5678_9ABC;
    pulse_start();
    @(negedge clk);
    @(negedge clk) wake_lines = 11'b000_0000_1000;
    repeat (2) @(negedge clk);
    chk("R7 raw bit3 ignored", pd_out, 7'b0000001);
    wake_lines = '0;
    rtc_count = 48'h1234_5678_9ABC;
    @(negedge clk) rtc_count = 48'h1234_5678_9ABD;
    chk("R7 timer cause", wake_cause, 11'b000_0000_1000);
    @(negedge clk);
    chk("R7 deep timer reset", cpu_reset_req, 1);
    @(negedge clk);
  endtask

  task automatic t_reject();
    cfg_deep = 1; cfg_pd_flags = 7'b0111111; wake_en = '1;
    reject_en = 2'b10; reject_lines = 2'b10;
    pulse_start();
    reject_lines = 2'b00;
    chk("R2 no pd check cycle", pd_out, 0);
    @(negedge clk);
    chk("R2 reject done", {done, rejected, cpu_reset_req}, 3'b110);
    chk("R2 no pd", pd_out, 0);
    chk("R2 no cause", wake_cause, 0);
    @(negedge clk);
    chk("R2 pulse ends", done, 0);
    // SDIO active, only GPIO reject enabled: entry proceeds
    cfg_deep = 0; reject_en = 2'b01; reject_lines = 2'b10; cfg_pd_flags = 7'b0000100;
    wake_en = 11'b000_0000_0010;
    pulse_start();
    reject_lines = 2'b00;
    @(negedge clk);
    chk("R2 unmasked enters", pd_out, 7'b0000100);
    @(negedge clk) wake_lines = 11'b000_0000_0010;
    @(negedge clk) wake_lines = '0;
    @(negedge clk);
    chk("R9 done no reject", {done, rejected}, 2'b10);
    @(negedge clk);
  endtask

  initial begin
    fork
      begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_light_uart();
        t_deep_masking();
        t_priority();
        t_disabled_line();
        t_timer();
        t_reject();
      end
      begin
        repeat (5000) @(posedge clk);
        fails++; checks++;
        $display("FAIL watchdog expired");
      end
    join_any
    disable fork;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule